// File: doc/BRIEF.md
# Saturating Q31 Add/Subtract Unit

This block adds or subtracts two signed 32-bit fixed-point words and clamps the answer to the signed 32-bit range instead of letting it wrap. Two of its four operations first double the second operand, with a clamp of their own, and then add that value to the first operand or subtract it. This form serves as the accumulate step after a fractional multiply, because the doubling realigns the product's binary point.

One operation is accepted on every cycle in which the valid strobe is high. A per-result saturation indication reports whether either stage clamped. It also feeds a sticky flag, which records that saturation has happened at some point since the flag was last cleared. Software or a sequencer clears the sticky flag through a dedicated clear input. A parameter selects whether the result leaves through an output register or straight from the datapath.

Top module: `q31_satunit`

## Requirements
- R1: The operation select uses 00 for add, 01 for subtract, 10 for doubled add and 11 for doubled subtract. When no stage leaves the signed 32-bit range, the result is the exact two's-complement value: a+b, a-b, a+2b or a-2b.
- R2: When the final add or subtract exceeds 2^31-1, the result is 0x7FFFFFFF. When it falls below -2^31, the result is 0x80000000.
- R3: In the doubled operations, a second operand of 0x40000000 to 0x7FFFFFFF doubles to 0x7FFFFFFF, and one of 0x80000000 to 0xBFFFFFFF doubles to 0x80000000. The final stage then operates on that clamped value.
- R4: `sat_o` is high with a result exactly when the doubling stage, the final stage, or both clamped for that result. It is low for all other results and whenever no result is presented.
- R5: Every valid operation that saturates sets `sat_sticky_o`. Operations that do not saturate leave it set.
- R6: `sat_sticky_o` falls only on a clock edge where `clr_sat_i` is high. If a saturating valid operation arrives in the same cycle as the clear, the flag ends up set.
- R7: With the default output register, a result, its `sat_o` and `res_valid_o` appear on the clock edge that samples `valid_i` high. On a cycle with `valid_i` low, `res_o` keeps its previous value and `res_valid_o` and `sat_o` are low, whatever the operands or operation select are.
- R8: While reset is held and after it is released, `res_o`, `sat_o`, `res_valid_o` and `sat_sticky_o` are all zero until the first operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Operation select (00 add, 01 sub, 10 doubled add, 11 doubled sub) |
| opa_i | input | 32 | First operand, signed |
| opb_i | input | 32 | Second operand, signed |
| clr_sat_i | input | 1 | Clears the sticky saturation flag |
| res_o | output | 32 | Saturated result |
| sat_o | output | 1 | Saturation occurred for this result |
| res_valid_o | output | 1 | Result strobe |
| sat_sticky_o | output | 1 | Sticky saturation flag |

## Verification
On every cycle, the assertions compare each accepted operation's result and saturation bit with a wide-integer model. They also check that saturation always sets the sticky flag, that the flag never falls without a clear, and that idle cycles hold the result. Only the bench scenarios can show particular boundary operands landing exactly on or just past the clamp limits in both stages. The same applies to a clear colliding with a saturating operation, and to the sticky flag surviving long runs of in-range traffic.

// File: rtl/q31_pkg.sv
// Package: shared operation encoding for the saturating Q31 unit.
// Assumes: op select bit 1 chooses doubling, bit 0 chooses subtraction.
package q31_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_DADD = 2'b10,
        OP_DSUB = 2'b11
    } q31_op_e;
endpackage

// File: rtl/q31_doubler.sv
// Module: q31_doubler
// Multiplies a signed word by two and clamps to the signed range.
// Assumes: W >= 2; purely combinational.
module q31_doubler #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    output logic [W-1:0] y_o,
    output logic         sat_o
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    // Shift left; a change of the top bit means the doubled value is out of range.
    always_comb begin
        sat_o = x_i[W-1] ^ x_i[W-2];
        if (sat_o) begin
            y_o = x_i[W-1] ? MINV : MAXV;
        end else begin
            y_o = {x_i[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/q31_addsub.sv
// Module: q31_addsub
// Signed add or subtract with clamping on overflow.
// Assumes: overflow is judged from operand and result sign bits; combinational.
module q31_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o,
    output logic         sat_o
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] b_eff;
    logic [W-1:0] raw;

    // Form a + b or a + ~b + 1 in one adder.
    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        raw   = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
    end

    // Same-sign addends that yield a different-sign sum have overflowed; clamp toward a's sign.
    always_comb begin
        sat_o = (a_i[W-1] == b_eff[W-1]) && (raw[W-1] != a_i[W-1]);
        if (sat_o) begin
            y_o = a_i[W-1] ? MINV : MAXV;
        end else begin
            y_o = raw;
        end
    end
endmodule

// File: rtl/q31_sticky.sv
// Module: q31_sticky
// Sticky flag: set dominates clear; holds otherwise.
// Assumes: synchronous active-low reset.
module q31_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Record saturation events until an explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/q31_satunit.sv
// Module: q31_satunit (top)
// Saturating add/sub with optional doubling of the second operand,
// a per-result saturation bit and a sticky saturation flag.
// Assumes: REG_OUT=1 registers outputs (one-cycle latency); REG_OUT=0
// presents them combinationally, with the sticky flag still registered.
module q31_satunit #(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         clr_sat_i,
    output logic [W-1:0] res_o,
    output logic         sat_o,
    output logic         res_valid_o,
    output logic         sat_sticky_o
);
    import q31_pkg::*;

    q31_op_e      op;
    logic         use_dbl;
    logic         use_sub;
    logic [W-1:0] dbl_val;
    logic         dbl_sat;
    logic [W-1:0] opb_sel;
    logic [W-1:0] fin_val;
    logic         fin_sat;
    logic         any_sat;
    logic         sat_evt;

    // Decode the operation select into its two control bits.
    always_comb begin
        op      = q31_op_e'(op_i);
        use_dbl = (op == OP_DADD) || (op == OP_DSUB);
        use_sub = (op == OP_SUB)  || (op == OP_DSUB);
    end

    q31_doubler #(.W(W)) u_dbl (
        .x_i   (opb_i),
        .y_o   (dbl_val),
        .sat_o (dbl_sat)
    );

    // Pick the plain or doubled second operand.
    always_comb begin
        opb_sel = use_dbl ? dbl_val : opb_i;
    end

    q31_addsub #(.W(W)) u_fin (
        .a_i   (opa_i),
        .b_i   (opb_sel),
        .sub_i (use_sub),
        .y_o   (fin_val),
        .sat_o (fin_sat)
    );

    // Merge the saturation events of both stages for an accepted operation.
    always_comb begin
        any_sat = fin_sat | (use_dbl & dbl_sat);
        sat_evt = valid_i & any_sat;
    end

    q31_sticky u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sat_evt),
        .clr_i  (clr_sat_i),
        .flag_o (sat_sticky_o)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic [W-1:0] res_q;
            logic         sat_q;
            logic         vld_q;

            // Capture accepted results; hold the last result when idle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_q <= '0;
                    sat_q <= 1'b0;
                    vld_q <= 1'b0;
                end else begin
                    vld_q <= valid_i;
                    sat_q <= sat_evt;
                    if (valid_i) begin
                        res_q <= fin_val;
                    end
                end
            end

            assign res_o       = res_q;
            assign sat_o       = sat_q;
            assign res_valid_o = vld_q;
        end else begin : g_comb
            // Present the datapath directly.
            assign res_o       = fin_val;
            assign sat_o       = sat_evt;
            assign res_valid_o = valid_i;
        end
    endgenerate
endmodule

// File: rtl/q31_satunit_chk.sv
// Module: q31_satunit_chk
// Assertion checker bound to q31_satunit; holds a wide-integer model.
// Assumes: the same W and REG_OUT as the instance it is bound to.
module q31_satunit_chk #(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid_i,
    input logic [1:0]   op_i,
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic         clr_sat_i,
    input logic [W-1:0] res_o,
    input logic         sat_o,
    input logic         res_valid_o,
    input logic         sat_sticky_o
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    // Model result: {saturated, value} computed at W+2 bits.
    function automatic logic [W:0] ref_calc(input logic [1:0] op,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
        logic signed [W+1:0] sa, sb, d, v;
        logic                f1, f2;
        logic [W-1:0]        r;
        sa = $signed({{2{a[W-1]}}, a});
        sb = $signed({{2{b[W-1]}}, b});
        f1 = 1'b0;
        if (op[1]) begin
            d  = sb <<< 1;
            f1 = (d[W+1:W-1] != 3'b000) && (d[W+1:W-1] != 3'b111);
            if (f1) sb = d[W+1] ? $signed({2'b11, MINV}) : $signed({2'b00, MAXV});
            else    sb = d;
        end
        v  = op[0] ? (sa - sb) : (sa + sb);
        f2 = (v[W+1:W-1] != 3'b000) && (v[W+1:W-1] != 3'b111);
        r  = f2 ? (v[W+1] ? MINV : MAXV) : v[W-1:0];
        return {f1 | f2, r};
    endfunction

    // R6
    sticky_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sat_sticky_o) |-> $past(clr_sat_i));

    // R4
    sat_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> res_valid_o);

    generate
        if (REG_OUT) begin : g_reg
            // R1
            result_model_chk: assert property (@(posedge clk) disable iff (!rst_n)
                valid_i |=> ({sat_o, res_o} == $past(ref_calc(op_i, opa_i, opb_i))));
            // R5
            sat_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (res_valid_o && sat_o) |-> sat_sticky_o);
            // R7
            idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !valid_i |=> ($stable(res_o) && !res_valid_o && !sat_o));
        end else begin : g_comb
            // R1
            result_model_chk: assert property (@(posedge clk) disable iff (!rst_n)
                valid_i |-> ({sat_o, res_o} == ref_calc(op_i, opa_i, opb_i)));
            // R5
            sat_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_i && sat_o) |=> sat_sticky_o);
        end
    endgenerate
endmodule

bind q31_satunit q31_satunit_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/test_q31_satunit.sv
`timescale 1ns/1ps
module test_q31_satunit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        clr_sat_i = 1'b0;
    logic [31:0] res_o;
    logic        sat_o;
    logic        res_valid_o;
    logic        sat_sticky_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    longint     exp_res = 0;
    bit         exp_sat = 0;
    bit         exp_vld = 0;
    bit         exp_stk = 0;
    longint     exp_q[$];

    always #2.5 clk = ~clk;

    q31_satunit i_q31_satunit (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (valid_i),
        .op_i         (op_i),
        .opa_i        (opa_i),
        .opb_i        (opb_i),
        .clr_sat_i    (clr_sat_i),
        .res_o        (res_o),
        .sat_o        (sat_o),
        .res_valid_o  (res_valid_o),
        .sat_sticky_o (sat_sticky_o)
    );

    function automatic longint clamp(input longint v, output bit hit);
        hit = 1'b0;
        if (v > 64'sd2147483647)   begin hit = 1'b1; return 64'sd2147483647; end
        if (v < -64'sd2147483648)  begin hit = 1'b1; return -64'sd2147483648; end
        return v;
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "res_o", longint'(res_o), exp_res & 64'hFFFF_FFFF);
        check(tag, "sat_o", longint'(sat_o), longint'(exp_sat));
        check(tag, "res_valid_o", longint'(res_valid_o), longint'(exp_vld));
        check(tag, "sat_sticky_o", longint'(sat_sticky_o), longint'(exp_stk));
    endtask

    // One clock: drive at negedge, model the edge, compare at the next negedge.
    task automatic step(input bit v, input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, input bit clr, input string tag);
        longint sa, sb, r;
        bit h1, h2;
        valid_i = v; op_i = op; opa_i = a; opb_i = b; clr_sat_i = clr;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        h1 = 1'b0;
        if (op[1]) sb = clamp(2 * sb, h1);
        r = op[0] ? (sa - sb) : (sa + sb);
        r = clamp(r, h2);
        exp_q.push_back(r);
        @(negedge clk);
        if (v) exp_res = exp_q.pop_back(); else void'(exp_q.pop_back());
        exp_vld = v;
        exp_sat = v && (h1 || h2);
        if (exp_sat) exp_stk = 1'b1; else if (clr) exp_stk = 1'b0;
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R8");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R8");
        // R1 exact in-range results for each encoding
        step(1, 2'b00, 32'd100, 32'd23, 0, "R1");
        step(1, 2'b01, 32'd5, 32'd9, 0, "R1");
        step(1, 2'b10, 32'hFFFF_FFF0, 32'd7, 0, "R1");
        step(1, 2'b11, 32'd1000, 32'h3FFF_FFFF, 0, "R1");
        check("R5", "sticky clean", longint'(sat_sticky_o), 0);
        // R2 final-stage clamps
        step(1, 2'b00, 32'h7FFF_FFFF, 32'd1, 0, "R2");
        step(1, 2'b01, 32'h8000_0000, 32'd1, 0, "R2");
        step(1, 2'b01, 32'd0, 32'h8000_0000, 0, "R2");
        step(1, 2'b01, 32'hFFFF_FFFF, 32'h8000_0000, 0, "R2");
        step(1, 2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R2");
        // R5 sticky holds across in-range work
        step(1, 2'b00, 32'd1, 32'd1, 0, "R5");
        step(1, 2'b01, 32'd7, 32'd3, 0, "R5");
        // R6 clear alone, then clear colliding with saturation
        step(0, 2'b00, 32'd0, 32'd0, 1, "R6");
        step(1, 2'b00, 32'd3, 32'd4, 0, "R6");
        step(1, 2'b10, 32'd0, 32'h4000_0000, 1, "R6");
        step(1, 2'b00, 32'd3, 32'd4, 1, "R6");
        // R3 doubling boundaries and saturation only in the doubling stage
        step(1, 2'b10, 32'd0, 32'h3FFF_FFFF, 0, "R3");
        step(1, 2'b10, 32'd0, 32'hC000_0000, 0, "R3");
        step(1, 2'b10, 32'hFFFF_FFFB, 32'h4000_0000, 0, "R3");
        step(1, 2'b11, 32'hFFFF_FFFF, 32'hBFFF_FFFF, 0, "R3");
        step(1, 2'b11, 32'h8000_0000, 32'h4000_0000, 0, "R4");
        step(0, 2'b11, 32'h8000_0000, 32'h4000_0000, 1, "R4");
        // R7 idle cycles with busy operands leave result held
        step(1, 2'b00, 32'd77, 32'd1, 0, "R7");
        step(0, 2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, "R7");
        step(0, 2'b11, 32'h1234_5678, 32'h8000_0000, 0, "R7");
        // Mixed traffic, corner-biased
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a, b;
            int sel;
            sel = int'($urandom_range(0, 5));
            a = $urandom;
            b = $urandom;
            if (sel == 0) b = 32'h4000_0000 - 32'($urandom_range(0, 2));
            if (sel == 1) b = 32'hC000_0000 - 32'($urandom_range(0, 2)) + 32'd1;
            if (sel == 2) a = 32'h7FFF_FFFF - 32'($urandom_range(0, 3));
            step(($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)), a, b,
                 ($urandom_range(0, 15) == 0), "R1");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule